// File: doc/BRIEF.md
# Absolute to Physical Address Mapper

This block turns an absolute address into a 40-bit physical address for accesses made while virtual translation is off. It is meant for the load/store and fetch path of a core. The result depends on two things: the wide-mode bit taken from the status word, and a bit that tells whether the core implements architecture level 2.0.

In wide mode the low 40 bits of the address go straight through. In narrow mode only the low 32 bits count, and their top two nibbles choose one of three regions. Memory addresses are zero-extended. I/O addresses are sign-extended. Firmware addresses keep their low 24 bits and are moved into the top of the 40-bit space. A core older than level 2.0 always zero-extends the low 32 bits.

The result is registered once. The output valid flag follows the input strobe one cycle later.

Top module: `abs_phys_mapper`

## Requirements
- R1: While reset is high, out_valid and out_phys are driven to zero from the next clock edge onward.
- R2: out_valid equals the value in_valid had one clock earlier, so the latency is one cycle.
- R3: With arch2=1 and wide=1, out_phys equals in_addr[39:0]; in_addr[63:40] has no effect.
- R4: With arch2=1 and wide=0, when in_addr[31:28] is not 4'hF the access is memory and out_phys = {8'h00, in_addr[31:0]}.
- R5: With arch2=1 and wide=0, when in_addr[31:28]=4'hF and in_addr[27:24] is nonzero the access is I/O and out_phys = {8'hFF, in_addr[31:0]}.
- R6: With arch2=1 and wide=0, when in_addr[31:28]=4'hF and in_addr[27:24]=4'h0 the access is firmware and out_phys = {4'hF, 12'h000, in_addr[23:0]}.
- R7: With arch2=0, out_phys = {8'h00, in_addr[31:0]} whatever the value of wide.
- R8: A cycle with in_valid=0 leaves out_phys unchanged, whatever in_addr, wide and arch2 are.
- R9: In narrow mode and on a pre-2.0 core, in_addr[63:32] has no effect on out_phys.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_addr and the mode bits as valid |
| in_addr | input | 64 | Absolute address to map |
| wide | input | 1 | Wide-mode bit from the status word |
| arch2 | input | 1 | 1 when the core implements architecture level 2.0 |
| out_valid | output | 1 | Registered copy of in_valid |
| out_phys | output | 40 | Registered physical address |

## Verification
The bench drives the addresses on either side of each region edge: 0xEFFFFFFF, 0xF0000000, 0xF0FFFFFF, 0xF1000000 and 0xFFFFFFFF. A decoder that tested the wrong nibble, or the wrong value of it, would put one of these in the wrong region. That error shows up as a wrong fill in bits 39:24.

Other addresses carry garbage in the unused upper bits. A former that read the wrong slice of the input would leak those bits into the result.

A pre-2.0 core is driven with the wide bit set. A design that let the wide bit win would pass bits 39:32 through instead of zeroing them.

Idle cycles with new address values check that the output register captures only on a valid strobe.

// File: rtl/abs_map_pkg.sv
package abs_map_pkg;

    localparam int unsigned ADDR_W    = 64;
    localparam int unsigned PHYS_W    = 40;
    localparam int unsigned NARROW_W  = 32;
    localparam int unsigned NIB_W     = 4;
    localparam int unsigned FW_KEEP_W = 24;
    localparam int unsigned FW_FILL_W = 4;

    typedef enum logic [2:0] {
        SPACE_WIDE   = 3'd0,
        SPACE_MEM    = 3'd1,
        SPACE_IO     = 3'd2,
        SPACE_FW     = 3'd3,
        SPACE_LEGACY = 3'd4
    } space_e;

    // The nibble that marks I/O or firmware space when every bit of it is one.
    function automatic logic nib_all_ones(input logic [NIB_W-1:0] n);
        return &n;
    endfunction

    function automatic logic nib_is_zero(input logic [NIB_W-1:0] n);
        return ~|n;
    endfunction

endpackage

// File: rtl/abs_space_decode.sv
module abs_space_decode
    import abs_map_pkg::*;
#(
    parameter int unsigned NARROW_W = abs_map_pkg::NARROW_W,
    parameter int unsigned NIB_W    = abs_map_pkg::NIB_W
) (
    input  logic [NARROW_W-1:0] addr_lo,
    input  logic                wide,
    input  logic                arch2,
    output space_e              space
);
    localparam int unsigned HI_MSB = NARROW_W - 1;
    localparam int unsigned LO_MSB = NARROW_W - NIB_W - 1;

    logic [NIB_W-1:0] tag_hi;
    logic [NIB_W-1:0] tag_lo;

    assign tag_hi = addr_lo[HI_MSB -: NIB_W];
    assign tag_lo = addr_lo[LO_MSB -: NIB_W];

    // Pre-2.0 cores have no wide mode, so the architecture level is tested first.
    always_comb begin
        if (!arch2)
            space = SPACE_LEGACY;
        else if (wide)
            space = SPACE_WIDE;
        else if (!nib_all_ones(tag_hi))
            space = SPACE_MEM;
        else if (!nib_is_zero(tag_lo))
            space = SPACE_IO;
        else
            space = SPACE_FW;
    end

endmodule

// File: rtl/abs_addr_form.sv
module abs_addr_form
    import abs_map_pkg::*;
#(
    parameter int unsigned PHYS_W    = abs_map_pkg::PHYS_W,
    parameter int unsigned NARROW_W  = abs_map_pkg::NARROW_W,
    parameter int unsigned FW_KEEP_W = abs_map_pkg::FW_KEEP_W,
    parameter int unsigned FW_FILL_W = abs_map_pkg::FW_FILL_W
) (
    input  space_e            space,
    input  logic [PHYS_W-1:0] addr,
    output logic [PHYS_W-1:0] phys
);
    localparam int unsigned FILL_LSB = PHYS_W - FW_FILL_W;
    localparam int unsigned SIGN_BIT = NARROW_W - 1;

    // One small multiplexer per output bit; each bit's source is fixed by its position.
    for (genvar i = 0; i < PHYS_W; i++) begin : g_bit
        localparam bit IN_NARROW = (i < NARROW_W);
        localparam bit IN_KEEP   = (i < FW_KEEP_W);
        localparam bit IN_FILL   = (i >= FILL_LSB);

        logic narrow_bit;
        logic io_bit;
        logic fw_bit;

        if (IN_NARROW) begin : g_low
            assign narrow_bit = addr[i];
            assign io_bit     = addr[i];
        end else begin : g_high
            assign narrow_bit = 1'b0;
            assign io_bit     = addr[SIGN_BIT];
        end

        if (IN_KEEP) begin : g_keep
            assign fw_bit = addr[i];
        end else begin : g_fill
            assign fw_bit = IN_FILL;
        end

        always_comb begin
            unique case (space)
                SPACE_WIDE: phys[i] = addr[i];
                SPACE_IO:   phys[i] = io_bit;
                SPACE_FW:   phys[i] = fw_bit;
                default:    phys[i] = narrow_bit;
            endcase
        end
    end

endmodule

// File: rtl/abs_out_reg.sv
module abs_out_reg #(
    parameter int unsigned PHYS_W = abs_map_pkg::PHYS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d_valid,
    input  logic [PHYS_W-1:0] d_phys,
    output logic              q_valid,
    output logic [PHYS_W-1:0] q_phys
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_phys  <= '0;
        end else begin
            q_valid <= d_valid;
            if (d_valid)
                q_phys <= d_phys;
        end
    end

endmodule

// File: rtl/abs_phys_mapper.sv
module abs_phys_mapper
    import abs_map_pkg::*;
#(
    parameter int unsigned ADDR_W    = abs_map_pkg::ADDR_W,
    parameter int unsigned PHYS_W    = abs_map_pkg::PHYS_W,
    parameter int unsigned NARROW_W  = abs_map_pkg::NARROW_W,
    parameter int unsigned NIB_W     = abs_map_pkg::NIB_W,
    parameter int unsigned FW_KEEP_W = abs_map_pkg::FW_KEEP_W,
    parameter int unsigned FW_FILL_W = abs_map_pkg::FW_FILL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              wide,
    input  logic              arch2,
    output logic              out_valid,
    output logic [PHYS_W-1:0] out_phys
);
    space_e            space;
    logic [PHYS_W-1:0] phys_d;
    logic              ign_unused_hi;

    // Bits above the physical width never reach the result.
    assign ign_unused_hi = ^in_addr[ADDR_W-1:PHYS_W];

    abs_space_decode #(
        .NARROW_W (NARROW_W),
        .NIB_W    (NIB_W)
    ) u_decode (
        .addr_lo (in_addr[NARROW_W-1:0]),
        .wide    (wide),
        .arch2   (arch2),
        .space   (space)
    );

    abs_addr_form #(
        .PHYS_W    (PHYS_W),
        .NARROW_W  (NARROW_W),
        .FW_KEEP_W (FW_KEEP_W),
        .FW_FILL_W (FW_FILL_W)
    ) u_form (
        .space (space),
        .addr  (in_addr[PHYS_W-1:0]),
        .phys  (phys_d)
    );

    abs_out_reg #(
        .PHYS_W (PHYS_W)
    ) u_oreg (
        .clk     (clk),
        .rst     (rst),
        .d_valid (in_valid),
        .d_phys  (phys_d),
        .q_valid (out_valid),
        .q_phys  (out_phys)
    );

endmodule

// File: rtl/abs_map_chk.sv
module abs_map_chk #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned PHYS_W = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              wide,
    input logic              arch2,
    input logic              out_valid,
    input logic [PHYS_W-1:0] out_phys
);
    logic narrow_go;
    logic sel_fx;
    logic sel_sub0;

    assign narrow_go = in_valid && arch2 && !wide;
    assign sel_fx    = (in_addr[31:28] == 4'hF);
    assign sel_sub0  = (in_addr[27:24] == 4'h0);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_phys == '0));

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    p_wide_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && arch2 && wide) |=> (out_phys == $past(in_addr[PHYS_W-1:0])));

    p_mem_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (narrow_go && !sel_fx) |=> (out_phys[39:32] == 8'h00 && out_phys[31:0] == $past(in_addr[31:0])));

    p_io_sign_r5: assert property (@(posedge clk) disable iff (rst)
        (narrow_go && sel_fx && !sel_sub0) |=> (out_phys[39:32] == 8'hFF));

    p_fw_reloc_r6: assert property (@(posedge clk) disable iff (rst)
        (narrow_go && sel_fx && sel_sub0) |=> (out_phys[39:36] == 4'hF && out_phys[35:24] == 12'h000));

    p_legacy_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !arch2) |=> (out_phys[39:32] == 8'h00));

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_phys));

endmodule

bind abs_phys_mapper abs_map_chk #(
    .ADDR_W (ADDR_W),
    .PHYS_W (PHYS_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .wide      (wide),
    .arch2     (arch2),
    .out_valid (out_valid),
    .out_phys  (out_phys)
);

// File: tb/sim_abs_phys_mapper.sv
module sim_abs_phys_mapper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic        wide = 1'b0;
    logic        arch2 = 1'b1;
    logic        out_valid;
    logic [39:0] out_phys;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    abs_phys_mapper u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .wide      (wide),
        .arch2     (arch2),
        .out_valid (out_valid),
        .out_phys  (out_phys)
    );

    function automatic logic [39:0] expect_phys(input logic [63:0] a, input logic w, input logic l2);
        if (!l2)                 return {8'h00, a[31:0]};
        if (w)                   return a[39:0];
        if (a[31:28] != 4'hF)    return {8'h00, a[31:0]};
        if (a[27:24] != 4'h0)    return {8'hFF, a[31:0]};
        return {4'hF, 12'h000, a[23:0]};
    endfunction

    task automatic check(input string req, input logic [39:0] got, input logic [39:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Inputs change at the falling edge, are captured at the rising edge, and are read at the next falling edge.
    task automatic map_one(input string req, input logic [63:0] a, input logic w, input logic l2);
        in_valid = 1'b1;
        in_addr  = a;
        wide     = w;
        arch2    = l2;
        @(negedge clk);
        check({req, " valid"}, {39'd0, out_valid}, 40'd1);
        check(req, out_phys, expect_phys(a, w, l2));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 valid", {39'd0, out_valid}, 40'd0);
        check("R1 phys", out_phys, 40'd0);
    endtask

    task automatic t_wide;
        map_one("R3 a", 64'hDEAD_BEEF_8123_4567, 1'b1, 1'b1);
        check("R3 a exact", out_phys, 40'hEF_8123_4567);
        map_one("R3 b", 64'h0000_0012_F000_0000, 1'b1, 1'b1);
        map_one("R3 c", 64'hFFFF_FF7F_FFFF_FFFF, 1'b1, 1'b1);
    endtask

    task automatic t_mem;
        map_one("R4 a", 64'h0000_0000_1234_5678, 1'b0, 1'b1);
        check("R4 a exact", out_phys, 40'h00_1234_5678);
        map_one("R4 edge", 64'h0000_0000_EFFF_FFFF, 1'b0, 1'b1);
        check("R4 edge exact", out_phys, 40'h00_EFFF_FFFF);
        map_one("R9 mem", 64'hABCD_EF01_8000_0001, 1'b0, 1'b1);
        check("R9 mem exact", out_phys, 40'h00_8000_0001);
    endtask

    task automatic t_io;
        map_one("R5 low", 64'h0000_0000_F100_0000, 1'b0, 1'b1);
        check("R5 low exact", out_phys, 40'hFF_F100_0000);
        map_one("R5 top", 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b1);
        map_one("R9 io", 64'h1234_5600_FA00_0010, 1'b0, 1'b1);
        check("R9 io exact", out_phys, 40'hFF_FA00_0010);
    endtask

    task automatic t_fw;
        map_one("R6 base", 64'h0000_0000_F000_0000, 1'b0, 1'b1);
        check("R6 base exact", out_phys, 40'hF0_0000_0000);
        map_one("R6 top", 64'h0000_0000_F0FF_FFFF, 1'b0, 1'b1);
        check("R6 top exact", out_phys, 40'hF0_00FF_FFFF);
        map_one("R9 fw", 64'h5555_5555_F0AB_CDEF, 1'b0, 1'b1);
        check("R9 fw exact", out_phys, 40'hF0_00AB_CDEF);
    endtask

    task automatic t_legacy;
        map_one("R7 narrow", 64'h0000_0000_F000_1234, 1'b0, 1'b0);
        check("R7 narrow exact", out_phys, 40'h00_F000_1234);
        map_one("R7 wide", 64'hFFFF_FFFF_F800_0000, 1'b1, 1'b0);
        check("R7 wide exact", out_phys, 40'h00_F800_0000);
    endtask

    task automatic t_hold;
        map_one("R8 prime", 64'h0000_0000_0BAD_CAFE, 1'b0, 1'b1);
        in_valid = 1'b0;
        in_addr  = 64'hFFFF_FFFF_FFFF_FFFF;
        wide     = 1'b1;
        @(negedge clk);
        check("R2 idle valid", {39'd0, out_valid}, 40'd0);
        check("R8 hold", out_phys, 40'h00_0BAD_CAFE);
        in_addr = 64'h0000_0000_F000_0000;
        wide    = 1'b0;
        arch2   = 1'b0;
        @(negedge clk);
        check("R8 hold again", out_phys, 40'h00_0BAD_CAFE);
        map_one("R2 resume", 64'h0000_0000_0000_0040, 1'b0, 1'b1);
    endtask

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        join_none

        repeat (2) @(negedge clk);
        t_reset;
        rst = 1'b0;
        t_wide;
        t_mem;
        t_io;
        t_fw;
        t_legacy;
        t_hold;
        in_valid = 1'b0;
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule